// File: doc/BRIEF.md
# Masked Lookup Table Remap Engine

This block holds a small lookup table in an internal register file and rewrites it in place for a new input mask M. When the rewrite finishes, reading the table at `b XOR M` returns the value that was stored at `b` before the rewrite. Software, or a neighbouring controller, loads the table through a write port, then issues a start strobe with the mask and a random seed. It then waits for the one-cycle done pulse and reads the remapped table through a registered read port.

The rewrite walks the mask bits one by one, in an order that a permutation derived from the seed selects. A clear bit costs one scan cycle. For a set bit `i`, the engine swaps every entry at an index with bit `i` clear with the entry whose index differs only in bit `i`. This is the same as exchanging each even-numbered block of `2^i` entries with the block after it. One entry pair is exchanged per cycle. The parameter `IDX_W` picks the table geometry: 4 gives 16 entries, 8 gives 256 entries. `DATA_W` sets the entry width, for example 4 or 8 bits.

Top module: `tbl_remap_engine`

## Requirements
- R1: After synchronous reset, `busy_o` and `done_o` are low and `rd_data_o` is zero.
- R2: While idle, `load_en_i` writes `load_data_i` at `load_addr_i`. A read issued at `rd_addr_i` while idle shows the stored entry on `rd_data_o` one clock later.
- R3: A `start_i` seen while idle captures `mask_i` and `seed_i`, and `busy_o` is high from the next cycle on.
- R4: When a run completes, the entry at index `b XOR M` equals the entry that was at `b` before the start, for every `b`.
- R5: With a zero mask, the table is unchanged and the run lasts exactly `IDX_W` busy cycles.
- R6: A run lasts exactly `IDX_W + popcount(M) * 2^(IDX_W-1)` busy cycles. That is one scan cycle per bit position plus one cycle per swapped pair.
- R7: Scan position `k` visits mask bit `((k XOR seed[LW-1:0]) + seed[2LW-1:LW]) mod IDX_W`, where `LW = log2(IDX_W)`. The table result and the run length do not depend on the seed.
- R8: `done_o` is high for exactly one cycle, in the first cycle in which `busy_o` is low again.
- R9: While busy, `load_en_i` and `start_i` have no effect on the table or on the mask in use, and `rd_data_o` holds its value.
- R10: With an all-ones mask, the table ends up in reversed index order: the new entry at `j` is the old entry at `~j`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en_i | input | 1 | Table write strobe, honoured only while idle |
| load_addr_i | input | IDX_W | Table write index |
| load_data_i | input | DATA_W | Table write value |
| start_i | input | 1 | Starts a remap run, honoured only while idle |
| mask_i | input | IDX_W | Mask M for the run |
| seed_i | input | 2*log2(IDX_W) | Random seed that selects the bit visiting order |
| rd_addr_i | input | IDX_W | Read index |
| rd_data_o | output | DATA_W | Registered read data, held while busy |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
A wrong pair address, or a skipped or doubled bit visit, leaves the table permuted by the wrong index XOR. This shows up as a mismatched read entry as soon as the table is read after `done_o`. A state machine that mishandles a clear bit or the last pair changes the busy length, so `done_o` comes one or more cycles early or late relative to `IDX_W + popcount(M) * 2^(IDX_W-1)`. Leaks through the load or start gating appear either as a changed entry after the run or as a `rd_data_o` change during busy cycles.

// File: rtl/tre_pkg.sv
package tre_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_SWAP = 2'd2
  } tre_state_e;
endpackage

// File: rtl/tre_bit_order.sv
// Maps a scan position to a mask bit index through a seed-keyed permutation.
module tre_bit_order #(
  parameter int IDX_W = 4,
  localparam int LW = $clog2(IDX_W)
) (
  input  logic [LW-1:0]   pos_i,
  input  logic [2*LW-1:0] seed_i,
  output logic [LW-1:0]   bit_o
);
  // XOR with a key, then add an offset: both steps are bijections modulo IDX_W (R7)
  always_comb begin
    bit_o = (pos_i ^ seed_i[LW-1:0]) + seed_i[2*LW-1:LW];
  end
endmodule

// File: rtl/tre_pair_addr.sv
// Expands a pair counter into the two indices that differ only at bit_i.
module tre_pair_addr #(
  parameter int IDX_W = 4,
  localparam int LW = $clog2(IDX_W)
) (
  input  logic [LW-1:0]    bit_i,
  input  logic [IDX_W-2:0] pair_i,
  output logic [IDX_W-1:0] lo_o,
  output logic [IDX_W-1:0] hi_o
);
  logic [IDX_W-1:0] ext;
  logic [IDX_W-1:0] low_mask;
  logic [IDX_W-1:0] sel_bit;

  always_comb begin
    ext      = IDX_W'(pair_i);
    sel_bit  = IDX_W'(1) << bit_i;
    low_mask = sel_bit - IDX_W'(1);
    // insert a zero at position bit_i
    lo_o     = ((ext & ~low_mask) << 1) | (ext & low_mask);
    hi_o     = lo_o | sel_bit;
  end
endmodule

// File: rtl/tre_regfile.sv
// Table storage: one load write port, one crosswise pair exchange, one registered read.
module tre_regfile #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_a,
  input  logic [IDX_W-1:0]  sw_b,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ent_a;
  logic [DATA_W-1:0] ent_b;

  assign ent_a = mem[sw_a];
  assign ent_b = mem[sw_b];

  always_ff @(posedge clk) begin
    if (sw_en) begin
      mem[sw_a] <= ent_b;
      mem[sw_b] <= ent_a;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_SWAP_ONE_BIT_APART: assert property (@(posedge clk) disable iff (rst) sw_en |-> $countones(sw_a ^ sw_b) == 1); // R4
  AST_NO_LOAD_DURING_SWAP: assert property (@(posedge clk) disable iff (rst) sw_en |-> !wr_en); // R9
endmodule

// File: rtl/tbl_remap_engine.sv
module tbl_remap_engine #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 4,
  localparam int LW     = $clog2(IDX_W),
  localparam int SEED_W = 2 * LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en_i,
  input  logic [IDX_W-1:0]  load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  mask_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  import tre_pkg::*;

  localparam logic [IDX_W-2:0] PAIR_LAST = '1;
  localparam logic [LW-1:0]    POS_LAST  = LW'(IDX_W - 1);

  tre_state_e        state_q;
  logic [LW-1:0]     pos_q;
  logic [IDX_W-2:0]  pair_q;
  logic [IDX_W-1:0]  mask_q;
  logic [SEED_W-1:0] seed_q;
  logic              done_q;
  logic [LW-1:0]     cur_bit;
  logic [IDX_W-1:0]  addr_lo;
  logic [IDX_W-1:0]  addr_hi;
  logic              idle;

  assign idle   = (state_q == ST_IDLE);
  assign busy_o = !idle;
  assign done_o = done_q;

  tre_bit_order #(.IDX_W(IDX_W)) u_order (
    .pos_i  (pos_q),
    .seed_i (seed_q),
    .bit_o  (cur_bit)
  );

  tre_pair_addr #(.IDX_W(IDX_W)) u_pair (
    .bit_i  (cur_bit),
    .pair_i (pair_q),
    .lo_o   (addr_lo),
    .hi_o   (addr_hi)
  );

  tre_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (load_en_i && idle),
    .wr_addr (load_addr_i),
    .wr_data (load_data_i),
    .sw_en   (state_q == ST_SWAP),
    .sw_a    (addr_lo),
    .sw_b    (addr_hi),
    .rd_en   (idle),
    .rd_addr (rd_addr_i),
    .rd_data (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      pair_q  <= '0;
      mask_q  <= '0;
      seed_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q  <= mask_i;
            seed_q  <= seed_i;
            pos_q   <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (mask_q[cur_bit]) begin
            pair_q  <= '0;
            state_q <= ST_SWAP;
          end else if (pos_q == POS_LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_SWAP: begin
          pair_q <= pair_q + 1'b1;
          if (pair_q == PAIR_LAST) begin
            if (pos_q == POS_LAST) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              pos_q   <= pos_q + 1'b1;
              state_q <= ST_SCAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst) (idle && start_i) |=> busy_o); // R3
  AST_SWAP_ONLY_SET_BIT: assert property (@(posedge clk) disable iff (rst) (state_q == ST_SWAP) |-> mask_q[cur_bit]); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R8
  AST_DONE_AT_BUSY_END: assert property (@(posedge clk) disable iff (rst) done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_RD_HELD_BUSY: assert property (@(posedge clk) disable iff (rst) (busy_o && $past(busy_o)) |-> $stable(rd_data_o)); // R9
  AST_MASK_HELD_BUSY: assert property (@(posedge clk) disable iff (rst) (busy_o && $past(busy_o)) |-> $stable(mask_q)); // R9
endmodule

// File: tb/tbl_remap_engine_test.sv
module tbl_remap_engine_test;
  localparam int IDX = 4;
  localparam int W   = 4;
  localparam int N   = 1 << IDX;
  localparam int SW  = 4;

  logic           clk = 1'b0;
  logic           rst;
  logic           load_en;
  logic [IDX-1:0] load_addr;
  logic [W-1:0]   load_data;
  logic           start;
  logic [IDX-1:0] mask;
  logic [SW-1:0]  seed;
  logic [IDX-1:0] rd_addr;
  logic [W-1:0]   rd_data;
  logic           busy;
  logic           done;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model [N];

  always #5 clk = ~clk;

  tbl_remap_engine #(.IDX_W(IDX), .DATA_W(W)) uut (
    .clk(clk), .rst(rst), .load_en_i(load_en), .load_addr_i(load_addr),
    .load_data_i(load_data), .start_i(start), .mask_i(mask), .seed_i(seed),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; load_en = 1'b0; load_addr = '0; load_data = '0;
    start = 1'b0; mask = '0; seed = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
  endtask

  task automatic load_random();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = IDX'(i); load_data = W'($urandom);
      model[i] = load_data;
    end
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); rd_addr = IDX'(i);
      @(posedge clk); @(negedge clk);
      chk(rd_data == model[i], req, rd_data, model[i]);
    end
  endtask

  function automatic void apply_model(input logic [IDX-1:0] m);
    logic [W-1:0] nxt [N];
    for (int b = 0; b < N; b++) nxt[b ^ int'(m)] = model[b];
    for (int b = 0; b < N; b++) model[b] = nxt[b];
  endfunction

  // returns busy length in cycles
  task automatic run(input logic [IDX-1:0] m, input logic [SW-1:0] s, output int cyc);
    @(negedge clk); start = 1'b1; mask = m; seed = s;
    @(posedge clk); cyc = 0;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    while (!done && cyc < 2000) begin
      cyc++;
      @(posedge clk); @(negedge clk);
    end
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    apply_model(m);
  endtask

  task automatic t_load_read();
    load_random();
    check_table("R2 load readback");
  endtask

  task automatic t_zero_mask();
    int c;
    run('0, 4'h9, c);
    chk(c == IDX, "R5 zero mask length", c, IDX);
    check_table("R5 zero mask table");
  endtask

  task automatic t_single_bits();
    int c;
    for (int i = 0; i < IDX; i++) begin
      run(IDX'(1) << i, SW'($urandom), c);
      chk(c == IDX + N / 2, "R6 single bit length", c, IDX + N / 2);
      check_table("R4 single bit table");
    end
  endtask

  task automatic t_all_ones();
    logic [W-1:0] old [N];
    int c;
    load_random();
    for (int i = 0; i < N; i++) old[i] = model[i];
    run('1, 4'h6, c);
    chk(c == IDX + IDX * N / 2, "R10 all ones length", c, IDX + IDX * N / 2);
    for (int j = 0; j < N; j++) chk(model[j] == old[(N - 1) - j], "R10 reversed model", model[j], old[(N - 1) - j]);
    check_table("R10 reversed table");
  endtask

  task automatic t_seed_independence();
    int c1;
    int c2;
    logic [IDX-1:0] m;
    for (int k = 0; k < 4; k++) begin
      m = IDX'($urandom);
      run(m, SW'(k * 5 + 1), c1);
      check_table("R7 seed A table");
      run(m, SW'(k * 3 + 10), c2);
      check_table("R7 seed B table");
      chk(c1 == c2, "R7 length vs seed", c2, c1);
      chk(c1 == IDX + $countones(m) * N / 2, "R6 length", c1, IDX + $countones(m) * N / 2);
    end
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] held;
    int cyc = 0;
    @(negedge clk); rd_addr = 4'h3;
    @(negedge clk); start = 1'b1; mask = 4'h5; seed = 4'h2;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    held = rd_data;
    while (!done && cyc < 2000) begin
      load_en = 1'b1; load_addr = IDX'(cyc); load_data = ~model[cyc % N];
      start = 1'b1; mask = 4'hA; seed = 4'hF;
      cyc++;
      @(posedge clk); @(negedge clk);
      if (busy) chk(rd_data == held, "R9 rd_data held", rd_data, held);
    end
    load_en = 1'b0; start = 1'b0;
    chk(cyc == IDX + 2 * N / 2, "R9 length unchanged", cyc, IDX + N);
    apply_model(4'h5);
    @(posedge clk); @(negedge clk);
    chk(busy == 1'b0, "R9 no restart", busy, 0);
    check_table("R9 table unaffected");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load_read();
    t_zero_mask();
    t_single_bits();
    t_all_ones();
    t_seed_independence();
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule